// File: doc/BRIEF.md
# T1 Data-Link Byte Serializer with Zero Insertion

This block sends one byte at a time over the data-link bit slots of an outgoing T1 stream. A host writes a byte into a holding register. The framer pulses a strobe once for every slot that belongs to the data link. On each strobe the block puts the next bit on its serial output, least significant bit first. When the last bit of a byte has been sent, the block sets an empty flag, and a maskable active-low interrupt can follow that flag. If the host has not written a new byte by then, the byte that was just sent goes out again.

Zero insertion is optional. When it is enabled, the block places a 0 in the slot that follows any five consecutive 1s. This keeps the stream from imitating an HDLC flag or abort. The count of consecutive 1s carries across byte boundaries. An inserted 0 takes up one slot, so the rest of the payload moves one slot later.

In D4 framing the same path carries the Fs framing bits (a holding value of 0x1C gives the correct pattern). In that mode a control input makes sure that new bytes enter the shifter only at multiframe boundaries.

Top module: `dl_byte_serializer`

## Requirements
- R1: Payload bits are sent least significant bit first. On each cycle with `slot_stb` high, `tx_bit` takes the next bit one clock later.
- R2: When the bit in position 7 of a byte is sent, `empty_flag` reads 1 one clock after that strobe.
- R3: A cycle with `wr_en` high stores `wr_data` and makes `empty_flag` read 0 one clock later.
- R4: `irq_n` is 0 exactly while `empty_flag` is 1 and `irq_mask` is 1, and 1 otherwise.
- R5: When no write has arrived since the last byte was loaded, the next byte sent is the same byte again.
- R6: With `stuff_en` at 1, the slot that follows five consecutive sent 1s carries a 0. The payload bit that would have used that slot goes out in the next slot.
- R7: The count of consecutive 1s continues across byte boundaries. Any 0 clears it, including an inserted 0.
- R8: With `stuff_en` at 0, no bit is inserted, so a byte of 0xFF gives an unbroken run of 1s.
- R9: With `mf_load_only` at 1, the holding value enters the shifter only on a byte-ending strobe during which `mf_boundary` is 1. Otherwise the shifter sends its current byte again. Loading 0x1C gives the D4 Fs pattern 0,0,1,1,1,0,0,0.
- R10: After reset, `tx_bit` is 0, `empty_flag` is 0, `irq_n` is 1, and the shifter and holding register both contain 0x00.
- R11: In cycles without `slot_stb`, `tx_bit` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| irq_mask | input | 1 | 1 lets the empty flag drive the interrupt |
| stuff_en | input | 1 | 1 enables zero insertion after five 1s |
| mf_load_only | input | 1 | 1 restricts shifter loads to multiframe boundaries |
| mf_boundary | input | 1 | Framer marks the multiframe boundary slot |
| slot_stb | input | 1 | Framer strobe, one per data-link slot |
| tx_bit | output | 1 | Serial data-link bit |
| empty_flag | output | 1 | Byte sent, holding register free |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A strobe registers its bit into `tx_bit` on the same edge, so the bit can be read one clock after the strobe. The monitor reads it one time unit after the edge on which it saw `slot_stb`. The empty flag changes one clock after the byte-ending strobe or after the write, and the bench reads it at the following falling edge. `irq_n` follows the flag and the mask with no added register. A reference model in the driver tracks the bit position, the run of 1s and the multiframe gating, and pushes each expected bit with its requirement tag into a queue that the monitor pops.

// File: rtl/dl_ser_pkg.sv
package dl_ser_pkg;
   typedef enum logic [1:0] {
      ACT_IDLE  = 2'd0,
      ACT_DATA  = 2'd1,
      ACT_STUFF = 2'd2
   } dl_act_e;

   function automatic int cnt_bits(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/dl_hold_reg.sv
module dl_hold_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         byte_done,
   input  logic         irq_mask,
   output logic [W-1:0] hold_q,
   output logic         empty_q,
   output logic         irq_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         empty_q <= 1'b0;
      end else begin
         if (wr_en) hold_q <= wr_data;
         if (wr_en)          empty_q <= 1'b0;
         else if (byte_done) empty_q <= 1'b1;
      end
   end

   assign irq_n = !(empty_q && irq_mask);

   a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !empty_q);
   a_r2_empty_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !wr_en) |=> empty_q);
endmodule

// File: rtl/dl_zero_stuffer.sv
module dl_zero_stuffer #(
   parameter int RUN_LEN = 5,
   parameter bit ENABLE  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slot_stb,
   input  logic stuff_en,
   input  logic data_bit,
   output logic insert
);
   import dl_ser_pkg::*;
   localparam int CW = cnt_bits(RUN_LEN);

   generate
      if (ENABLE) begin : g_stuff
         logic [CW-1:0] run_q;
         assign insert = stuff_en && slot_stb && (run_q == CW'(RUN_LEN));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   run_q <= '0;
            else if (slot_stb) begin
               if (insert || !data_bit)   run_q <= '0;
               else if (run_q != CW'(RUN_LEN)) run_q <= run_q + 1'b1;
            end
         end

         a_r7_run_capped: assert property (@(posedge clk) disable iff (!rst_n)
            run_q <= CW'(RUN_LEN));
      end else begin : g_bypass
         assign insert = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dl_shifter.sv
module dl_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance,
   input  logic [W-1:0] hold_q,
   input  logic         mf_load_only,
   input  logic         mf_boundary,
   output logic         cur_bit,
   output logic         byte_done
);
   import dl_ser_pkg::*;
   localparam int IW = cnt_bits(W - 1);

   logic [W-1:0]  shift_q;
   logic [IW-1:0] idx_q;
   logic          load_ok;

   assign cur_bit   = shift_q[idx_q];
   assign byte_done = advance && (idx_q == IW'(W - 1));
   assign load_ok   = !mf_load_only || mf_boundary;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         idx_q   <= '0;
      end else if (advance) begin
         if (byte_done) begin
            idx_q <= '0;
            if (load_ok) shift_q <= hold_q;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   a_r1_idx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(idx_q));
   a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IW'(W - 1));
   a_r9_no_load_off_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && mf_load_only && !mf_boundary) |=> $stable(shift_q));
endmodule

// File: rtl/dl_byte_serializer.sv
module dl_byte_serializer #(
   parameter int W             = 8,
   parameter int RUN_LEN       = 5,
   parameter bit STUFF_SUPPORT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         irq_mask,
   input  logic         stuff_en,
   input  logic         mf_load_only,
   input  logic         mf_boundary,
   input  logic         slot_stb,
   output logic         tx_bit,
   output logic         empty_flag,
   output logic         irq_n
);
   import dl_ser_pkg::*;
   localparam int CW = cnt_bits(RUN_LEN);

   generate
      if (W < 2)       begin : g_bad_w   $error("W must be at least 2");       end
      if (RUN_LEN < 1) begin : g_bad_run $error("RUN_LEN must be at least 1"); end
   endgenerate

   logic    [W-1:0] hold_q;
   logic            cur_bit, byte_done, insert, tx_q;
   dl_act_e         act;

   assign act = !slot_stb ? ACT_IDLE : (insert ? ACT_STUFF : ACT_DATA);

   dl_hold_reg #(.W(W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .byte_done(byte_done), .irq_mask(irq_mask),
      .hold_q(hold_q), .empty_q(empty_flag), .irq_n(irq_n));

   dl_zero_stuffer #(.RUN_LEN(RUN_LEN), .ENABLE(STUFF_SUPPORT)) u_stuff (
      .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .stuff_en(stuff_en),
      .data_bit(cur_bit), .insert(insert));

   dl_shifter #(.W(W)) u_shift (
      .clk(clk), .rst_n(rst_n), .advance(act == ACT_DATA), .hold_q(hold_q),
      .mf_load_only(mf_load_only), .mf_boundary(mf_boundary),
      .cur_bit(cur_bit), .byte_done(byte_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_q <= 1'b0;
      else begin
         case (act)
            ACT_DATA:  tx_q <= cur_bit;
            ACT_STUFF: tx_q <= 1'b0;
            default:   tx_q <= tx_q;
         endcase
      end
   end
   assign tx_bit = tx_q;

   // checker: run of ones seen on the output pin
   logic          stb_d;
   logic [CW-1:0] chk_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_d   <= 1'b0;
         chk_run <= '0;
      end else begin
         stb_d <= slot_stb;
         if (stb_d) begin
            if (!tx_q)                        chk_run <= '0;
            else if (chk_run != CW'(RUN_LEN)) chk_run <= chk_run + 1'b1;
         end
      end
   end

   a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (empty_flag && irq_mask));
   a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_stb |=> $stable(tx_bit));
   a_r6_zero_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      (STUFF_SUPPORT && slot_stb && !stb_d && stuff_en && chk_run == CW'(RUN_LEN)) |=> !tx_bit);
endmodule

// File: tb/dl_byte_serializer_tb_top.sv
module dl_byte_serializer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       irq_mask = 1'b0, stuff_en = 1'b0, mf_load_only = 1'b0;
   logic       mf_boundary = 1'b0, slot_stb = 1'b0;
   logic       tx_bit, empty_flag, irq_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit    exp_q[$];
   string tag_q[$];

   // reference model state
   logic [7:0] m_hold = 8'h00, m_shift = 8'h00;
   int         m_idx = 0, m_run = 0;
   bit         m_empty = 1'b0;

   always #5 clk = ~clk;

   dl_byte_serializer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .irq_mask(irq_mask), .stuff_en(stuff_en), .mf_load_only(mf_load_only),
      .mf_boundary(mf_boundary), .slot_stb(slot_stb),
      .tx_bit(tx_bit), .empty_flag(empty_flag), .irq_n(irq_n));

   task automatic check(input string tag, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   // monitor
   always @(posedge clk) begin
      if (slot_stb) begin
         #1;
         if (exp_q.size() == 0) check("R1 unexpected bit", 1'b1, 1'b0);
         else check(tag_q.pop_front(), tx_bit, exp_q.pop_front());
      end
   end

   task automatic host_write(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      m_hold = d; m_empty = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic strobe(input string tag);
      bit e;
      @(negedge clk);
      slot_stb = 1'b1;
      if (stuff_en && m_run == 5) begin
         e = 1'b0; m_run = 0;
      end else begin
         e = m_shift[m_idx];
         m_run = e ? ((m_run < 5) ? m_run + 1 : 5) : 0;
         if (m_idx == 7) begin
            m_idx = 0; m_empty = 1'b1;
            if (!mf_load_only || mf_boundary) m_shift = m_hold;
         end else m_idx++;
      end
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      slot_stb = 1'b0;
   endtask

   task automatic strobes(input int n, input string tag);
      for (int i = 0; i < n; i++) strobe(tag);
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic held;
      repeat (3) @(negedge clk);
      check("R10 tx reset", tx_bit, 1'b0);
      check("R10 empty reset", empty_flag, 1'b0);
      check("R10 irq reset", irq_n, 1'b1);
      rst_n = 1'b1;

      host_write(8'hA5);
      check("R3 empty after write", empty_flag, 1'b0);
      strobes(8, "R10 reset shifter zero");
      check("R2 empty after byte", empty_flag, 1'b1);
      check("R4 masked irq", irq_n, 1'b1);
      irq_mask = 1'b1; #1;
      check("R4 irq asserted", irq_n, 1'b0);
      host_write(8'h3C);
      check("R3 write clears", empty_flag, 1'b0);
      check("R4 irq released", irq_n, 1'b1);
      strobes(3, "R1 lsb first A5");
      check("R2 not empty mid byte", empty_flag, 1'b0);
      strobes(5, "R1 lsb first A5");
      check("R2 empty again", empty_flag, 1'b1);
      strobes(8, "R1 byte 3C");
      strobes(8, "R5 repeat 3C");

      // R11: idle cycles leave the output alone
      held = tx_bit;
      repeat (6) @(negedge clk);
      check("R11 idle hold", tx_bit, held);

      // zero insertion across byte boundaries
      stuff_en = 1'b1;
      host_write(8'hF0);
      strobes(8, "R6 flush 3C");
      host_write(8'h0F);
      strobes(9, "R7 run across boundary F0/0F");
      host_write(8'hFF);
      strobes(10, "R7 run across boundary F0/0F");
      strobes(30, "R6 stuffing FF");

      // stuffing off
      stuff_en = 1'b0;
      strobes(24, "R8 no insertion FF");

      // multiframe-gated loading, D4 Fs pattern
      mf_load_only = 1'b1;
      host_write(8'h1C);
      strobes(16, "R9 no load off boundary");
      mf_boundary = 1'b1;
      strobes(8, "R9 load at boundary");
      mf_boundary = 1'b0;
      strobes(16, "R9 Fs pattern 1C");

      repeat (3) @(negedge clk);
      check("R1 all bits seen", exp_q.size() == 0, 1'b1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule